// File: doc/BRIEF.md
# Subcarrier Reset and Serial Frequency Receiver

This block serves one multipurpose input pin of a video encoder. A 2-bit mode input decides how the pin is read. In subcarrier-reset mode, a rising edge on the pin arms a phase reset. The reset is not applied at once. It is issued as a one-cycle pulse when the next field-start strobe arrives, and it returns the subcarrier to field 0.

In serial-frequency mode, an external video decoder sends a fixed-length serial frame on the pin. The block deserializes the frame and keeps its low 22 bits, which are the compensated subcarrier frequency. It holds that value in a shadow register. At the next line-start strobe it presents the value on the active frequency output, so the oscillator can follow line-length variation one line at a time.

When serial-frequency mode is not selected, the active frequency output passes the software frequency registers straight through. The pin is taken to be synchronous to the clock.

Top module: `sc_rtc_rx`

## Requirements
- R1: `mode_i` encoding: 2'b01 selects subcarrier-reset mode, 2'b10 selects serial-frequency mode, and 2'b00 or 2'b11 selects neither. Outside serial-frequency mode, `freq_o` equals `freq_reg_i` in the same cycle.
- R2: In subcarrier-reset mode, a low-to-high transition of `pin_i` arms a reset. The arm is then held. When the next `field_start_i` strobe is sampled, `sc_reset_o` is high for exactly the following cycle, and the arm is cleared.
- R3: A `field_start_i` strobe with no armed reset gives no pulse. A rising edge sampled in the same cycle as a field strobe arms the reset for the next field strobe, not for that one.
- R4: Several rising edges before one field strobe give a single pulse. A second field strobe after that pulse gives none.
- R5: Leaving subcarrier-reset mode clears the arm. Edges on `pin_i` in any other mode never produce `sc_reset_o`.
- R6: Serial frame format. The line idles high. A frame begins with a low start bit that follows a high cycle. The start bit is followed by 67 data bits, bit 0 first. Every bit lasts 2 clock cycles and is sampled on its second cycle. Bits 0 to 21 carry the frequency value, and bits 22 to 66 are ignored.
- R7: A received value reaches `freq_o` only when the first `line_start_i` strobe after the frame ends is sampled, and it is visible in the following cycle. It appears in `freq_o[21:0]`, and the upper bits are zero. When two frames arrive before one strobe, only the later value is applied.
- R8: A start bit that is high again on its second cycle is rejected, and no value is taken from it.
- R9: In serial-frequency mode, `freq_reg_i` has no effect on `freq_o`.
- R10: After reset, `sc_reset_o` is 0 and the serial-mode active value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Shared reset / serial frequency pin |
| mode_i | input | 2 | Pin mode select |
| field_start_i | input | 1 | Field-start strobe |
| line_start_i | input | 1 | Line-start strobe |
| freq_reg_i | input | FREQ_W (32) | Software subcarrier frequency registers |
| sc_reset_o | output | 1 | Subcarrier phase-reset pulse |
| freq_o | output | FREQ_W (32) | Active subcarrier frequency word |

## Verification
If the arm flag is stuck or left set, the fault shows up at the first field strobe after the triggering pin activity, as a pulse that is missing or an extra pulse. A deserializer that slips by one bit or samples on the wrong phase shifts or corrupts the 22-bit value. That fault is visible in `freq_o` one cycle after the next line strobe. A shadow stage that is skipped shows up earlier, because `freq_o` then changes before any line strobe. Frames with random upper bits, together with nonzero register values, expose any leak of the ignored bits or of `freq_reg_i` into the output.

// File: rtl/sc_rtc_pkg.sv
package sc_rtc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SCRST = 2'b01,
    MODE_RTC   = 2'b10,
    MODE_OFF2  = 2'b11
  } sc_mode_e;

  localparam int unsigned FRAME_BITS = 67;
  localparam int unsigned VAL_W      = 22;
  localparam int unsigned FREQ_W     = 32;
endpackage

// File: rtl/sc_arm.sv
module sc_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_i,
  input  logic pin_q_i,
  input  logic field_start_i,
  output logic sc_reset_o
);
  logic armed_q, armed_d, pulse_d, rise;

  assign rise    = en_i & pin_i & ~pin_q_i;
  assign armed_d = en_i & (rise | (armed_q & ~field_start_i));
  assign pulse_d = en_i & armed_q & field_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      sc_reset_o <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      sc_reset_o <= pulse_d;
    end
  end

  a_r2_after_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_reset_o |-> $past(field_start_i));
  a_r5_off_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!armed_q && !sc_reset_o));
endmodule

// File: rtl/sc_rtc_deser.sv
module sc_rtc_deser #(
  parameter int unsigned FRAME_BITS = 67,
  parameter int unsigned VAL_W      = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pin_i,
  input  logic             pin_q_i,
  output logic [VAL_W-1:0] word_o,
  output logic             word_vld_o
);
  localparam int unsigned LAST_CNT = 2 * FRAME_BITS + 1;
  localparam int unsigned CNT_W    = $clog2(LAST_CNT + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] bit_idx;
  logic             sample;

  // cnt_q counts cycles since the start-bit fall; odd counts >= 3 are data sample points
  assign sample  = busy_q && (cnt_q >= CNT_W'(3)) && cnt_q[0];
  assign bit_idx = (cnt_q - CNT_W'(3)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
    end else if (!en_i) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (!busy_q) begin
        if (pin_q_i && !pin_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(1);
        end
      end else if (cnt_q == CNT_W'(1) && pin_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (cnt_q == CNT_W'(LAST_CNT)) begin
        busy_q     <= 1'b0;
        cnt_q      <= '0;
        word_vld_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < VAL_W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_o[g] <= 1'b0;
      else if (en_i && sample && bit_idx == CNT_W'(g)) word_o[g] <= pin_i;
    end
  end

  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LAST_CNT));
  a_r6_vld_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> ($past(cnt_q) == CNT_W'(LAST_CNT)));
endmodule

// File: rtl/sc_freq_sel.sv
module sc_freq_sel #(
  parameter int unsigned VAL_W  = 22,
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [VAL_W-1:0]  word_i,
  input  logic              word_vld_i,
  input  logic              line_start_i,
  input  logic [FREQ_W-1:0] freq_reg_i,
  output logic [FREQ_W-1:0] freq_o
);
  localparam int unsigned PAD_W = FREQ_W - VAL_W;

  logic [VAL_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (en_i && word_vld_i)   shadow_q <= word_i;
      if (en_i && line_start_i) active_q <= shadow_q;
    end
  end

  assign freq_o = en_i ? {{PAD_W{1'b0}}, active_q} : freq_reg_i;

  a_r7_line_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(active_q));
endmodule

// File: rtl/sc_rtc_rx.sv
module sc_rtc_rx
  import sc_rtc_pkg::*;
#(
  parameter int unsigned P_FRAME_BITS = FRAME_BITS,
  parameter int unsigned P_VAL_W      = VAL_W,
  parameter int unsigned P_FREQ_W     = FREQ_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pin_i,
  input  logic [1:0]          mode_i,
  input  logic                field_start_i,
  input  logic                line_start_i,
  input  logic [P_FREQ_W-1:0] freq_reg_i,
  output logic                sc_reset_o,
  output logic [P_FREQ_W-1:0] freq_o
);
  logic pin_q, rst_mode, rtc_mode, word_vld;
  logic [P_VAL_W-1:0] word;

  assign rst_mode = (mode_i == MODE_SCRST);
  assign rtc_mode = (mode_i == MODE_RTC);

  // idle-high reset value: no false edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b1;
    else         pin_q <= pin_i;
  end

  sc_arm u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (rst_mode),
    .pin_i        (pin_i),
    .pin_q_i      (pin_q),
    .field_start_i(field_start_i),
    .sc_reset_o   (sc_reset_o)
  );

  sc_rtc_deser #(.FRAME_BITS(P_FRAME_BITS), .VAL_W(P_VAL_W)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rtc_mode),
    .pin_i     (pin_i),
    .pin_q_i   (pin_q),
    .word_o    (word),
    .word_vld_o(word_vld)
  );

  sc_freq_sel #(.VAL_W(P_VAL_W), .FREQ_W(P_FREQ_W)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rtc_mode),
    .word_i      (word),
    .word_vld_i  (word_vld),
    .line_start_i(line_start_i),
    .freq_reg_i  (freq_reg_i),
    .freq_o      (freq_o)
  );

  a_r1_no_pulse_in_rtc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtc_mode && $past(rtc_mode)) |-> !sc_reset_o);
endmodule

// File: tb/tb_sc_rtc_rx.sv
`timescale 1ns/1ps
module tb_sc_rtc_rx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin = 1'b1;
  logic [1:0]  mode = 2'b10;
  logic        field = 1'b0;
  logic        line = 1'b0;
  logic [31:0] freq_reg = '0;
  logic        sc_reset;
  logic [31:0] freq;

  int n_chk = 0, n_bad = 0, pulses = 0;
  logic [21:0] exp_act = '0;

  sc_rtc_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .mode_i(mode),
    .field_start_i(field), .line_start_i(line), .freq_reg_i(freq_reg),
    .sc_reset_o(sc_reset), .freq_o(freq)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) if (sc_reset) pulses++;

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_freq(logic [21:0] a);
    return {10'b0, a};
  endfunction

  task automatic rise();
    pin = 1'b0; tick();
    pin = 1'b1; tick();
  endtask

  task automatic field_chk(string req, logic exp);
    field = 1'b1; tick();
    field = 1'b0;
    check(req, {31'b0, sc_reset}, {31'b0, exp});
    tick();
    check(req, {31'b0, sc_reset}, 32'b0);
  endtask

  task automatic send_frame(logic [21:0] v, logic [44:0] hi);
    logic [66:0] fr;
    fr = {hi, v};
    pin = 1'b1; tick(3);
    pin = 1'b0; tick(2);
    for (int k = 0; k < 67; k++) begin
      pin = fr[k]; tick(2);
    end
    pin = 1'b1; tick(3);
  endtask

  task automatic line_chk(string req);
    line = 1'b1; tick();
    line = 1'b0;
    check(req, freq, exp_freq(exp_act));
  endtask

  initial begin
    tick(5);
    check("R10", {31'b0, sc_reset}, 32'b0);
    check("R10", freq, 32'b0);
    rst_ni = 1'b1;
    tick(2);
    check("R10", freq, 32'b0);
  end

  initial begin
    logic [21:0] v;
    logic [44:0] hi;
    int p0;
    void'($urandom(32'd2024));
    @(posedge rst_ni); tick(3);

    // R1 pass-through in non-serial modes
    mode = 2'b00; freq_reg = $urandom(); tick();
    check("R1", freq, freq_reg);
    mode = 2'b11; freq_reg = $urandom(); tick();
    check("R1", freq, freq_reg);
    mode = 2'b01; freq_reg = $urandom(); tick();
    check("R1", freq, freq_reg);

    // R3 no arm -> no pulse
    field_chk("R3", 1'b0);
    // R2 armed reset issued at next field strobe, then cleared
    rise(); tick(4);
    check("R2", {31'b0, sc_reset}, 32'b0);
    field_chk("R2", 1'b1);
    field_chk("R2", 1'b0);
    // R4 multiple edges -> single pulse
    rise(); rise(); rise(); tick(2);
    field_chk("R4", 1'b1);
    field_chk("R4", 1'b0);
    // R3 edge coincident with field strobe arms for next field
    pin = 1'b0; tick();
    pin = 1'b1; field = 1'b1; tick();
    field = 1'b0;
    check("R3", {31'b0, sc_reset}, 32'b0);
    tick();
    check("R3", {31'b0, sc_reset}, 32'b0);
    field_chk("R3", 1'b1);
    // R5 leaving mode clears arm
    rise();
    mode = 2'b00; tick();
    mode = 2'b01; tick();
    field_chk("R5", 1'b0);
    // R5 edges in other modes do nothing
    mode = 2'b11; rise(); rise();
    field_chk("R5", 1'b0);
    mode = 2'b01; tick();
    field_chk("R5", 1'b0);

    // serial mode
    mode = 2'b10; freq_reg = '0; tick();
    check("R7", freq, exp_freq(exp_act));
    p0 = pulses;
    v = 22'h2a5c3e; send_frame(v, '1);
    check("R7", freq, exp_freq(exp_act));
    exp_act = v;
    line_chk("R6");
    // directed all-ones / all-zeros values
    send_frame(22'h3fffff, '0); exp_act = 22'h3fffff; line_chk("R6");
    send_frame(22'h000000, '1); exp_act = 22'h000000; line_chk("R6");
    // R7 two frames, one strobe: later value wins
    send_frame(22'h12345, '0);
    send_frame(22'h0abcde, '1);
    exp_act = 22'h0abcde; line_chk("R7");
    // R8 start glitch rejected
    pin = 1'b0; tick();
    pin = 1'b1; tick(4);
    line_chk("R8");
    // R8 glitch then valid frame still received
    send_frame(22'h155555, '0); exp_act = 22'h155555; line_chk("R8");
    // random frames, random registers (R9) and ignored high bits (R6)
    for (int i = 0; i < 20; i++) begin
      v  = 22'($urandom());
      hi = 45'({$urandom(), $urandom()});
      freq_reg = $urandom();
      send_frame(v, hi);
      check("R9", freq, exp_freq(exp_act));
      tick($urandom_range(0, 5));
      exp_act = v;
      line_chk("R7");
      check("R7", {22'b0, freq[31:22]}, 32'b0);
    end
    check("R5", pulses - p0, 32'd0);
    mode = 2'b00; tick();
    check("R1", freq, freq_reg);
    mode = 2'b10; tick();
    check("R9", freq, exp_freq(exp_act));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule